// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the external machine cycles for a small 8-bit processor core. The core presents one request at a time, made of a cycle kind, a 16-bit address and a write byte. The controller steps through the states T1, T2, optional wait states, and T3. In T1 it places the low address byte on a shared low bus and pulses an address latch strobe. In the later states the same bus carries data. The upper address byte has its own output bus.

Each cycle kind shows a three-bit status code on the memory/IO select and two status pins. Reads, writes and interrupt acknowledges each use their own active-low strobe. A slow device holds the ready input low to stretch a cycle. When a bus master raises hold, the controller grants the bus between cycles. It then releases every address, data, strobe and select output, which is shown by output-enable pins. When the cycle ends, the read byte and a one-clock done pulse go back to the core.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset the strobes rd_n, wr_n and inta_n are high, ale, hlda, ad_oe and rsp_done are low, and req_ready is high.
- R2: A request is accepted on a clock edge where req_ready and req_valid are both high. In the next clock (T1), ale is high, ad_out carries address bits 7..0 with ad_oe high, and a_hi carries address bits 15..8. ale is high for exactly one clock.
- R3: {io_m, s1, s0} follows the latched kind. req_kind values are fetch=0, memory read=1, memory write=2, IO read=3, IO write=4, interrupt acknowledge=5 and halt=6. They give the codes 011, 010, 001, 110, 101, 111 and 000 respectively, and value 7 is reserved. io_m is 1 for IO and 0 for memory.
- R4: Fetch, memory read and IO read cycles hold rd_n low through T2, any wait states and T3, with ad_oe low. On the edge that ends T3, ad_in is captured into rsp_rdata.
- R5: Memory write and IO write cycles hold wr_n low from T2 through T3, and drive wdata on ad_out with ad_oe high.
- R6: An interrupt acknowledge cycle lowers inta_n, not rd_n, over the same states, and captures its opcode from ad_in.
- R7: ready is sampled at each edge in T2 or a wait state. While it is low, a wait state follows and the strobe stays asserted, so the strobe is low for 2 plus the number of low samples clocks.
- R8: hold is honoured only between cycles, taking priority over a pending request. hlda rises one clock after hold is seen. While hlda is high, ad_oe, addr_oe and strobe_oe are all low.
- R9: Once hold drops, hlda falls at the next edge. The outputs stay released for that one clock, and addr_oe and strobe_oe return one clock later.
- R10: A halt request gives a done pulse and enters the halt state. There, status is 000, addr_oe and ad_oe are low and the strobes stay high. A later request of another kind starts a normal cycle from halt.
- R11: rsp_done is a single-clock pulse in the clock after T3 (or after a halt is accepted). req_ready is high only in idle or halt while hold is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core has a request |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request accepted on this edge if valid |
| rsp_rdata | output | 8 | Byte captured at end of read |
| rsp_done | output | 1 | One-clock completion pulse |
| ready | input | 1 | Device ready; low inserts wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant |
| ad_out | output | 8 | Shared low bus, driven value |
| ad_in | input | 8 | Shared low bus, received value |
| ad_oe | output | 1 | Drive enable for the shared low bus |
| a_hi | output | 8 | Upper address byte |
| addr_oe | output | 1 | Drive enable for a_hi and io_m |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| strobe_oe | output | 1 | Drive enable for the three strobes |
| io_m | output | 1 | 1 for IO, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |

## Verification
The assertions assume that hold and ready change only between clock edges. They also assume that req_kind never carries the reserved value 7 while req_valid is high. The stimulus drives every input on the falling edge and uses only the kinds 0 to 6. It raises hold both while idle and partway through a stretched cycle, so that the boundary rule and the one-clock regain gap are both seen at the pins.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4,
        K_INTA  = 3'd5,
        K_HALT  = 3'd6,
        K_RSVD  = 3'd7
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_T1, S_T2, S_TW, S_T3, S_HALT, S_HOLD, S_REGAIN
    } state_e;

    // {io_m, s1, s0}
    function automatic logic [2:0] status_code(kind_e k);
        case (k)
            K_FETCH: return 3'b011;
            K_MRD:   return 3'b010;
            K_MWR:   return 3'b001;
            K_IORD:  return 3'b110;
            K_IOWR:  return 3'b101;
            K_INTA:  return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic is_rd(kind_e k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic is_wr(kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

endpackage

// File: rtl/bcc_seq.sv
module bcc_seq
    import bcc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ready,
    input  logic          hold,
    input  logic [DW-1:0] ad_in,
    output state_e        st_o,
    output kind_e         kind_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic [DW-1:0] rdata_o,
    output logic          done_o,
    output logic          req_ready_o
);

    typedef struct packed {
        state_e        st;
        kind_e         kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          done;
    } seq_t;

    seq_t r_q, r_d;
    logic take;

    assign req_ready_o = ((r_q.st == S_IDLE) || (r_q.st == S_HALT)) && !hold;
    assign take        = req_ready_o && req_valid;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            S_IDLE, S_HALT: begin
                if (hold) begin
                    r_d.st = S_HOLD;
                end else if (take) begin
                    r_d.kind  = kind_e'(req_kind);
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    if (kind_e'(req_kind) == K_HALT) begin
                        r_d.st   = S_HALT;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = S_T1;
                    end
                end
            end
            S_T1:       r_d.st = S_T2;
            S_T2, S_TW: r_d.st = ready ? S_T3 : S_TW;
            S_T3: begin
                r_d.st   = S_IDLE;
                r_d.done = 1'b1;
                if (is_rd(r_q.kind) || (r_q.kind == K_INTA)) begin
                    r_d.rdata = ad_in;
                end
            end
            S_HOLD:   r_d.st = hold ? S_HOLD : S_REGAIN;
            S_REGAIN: r_d.st = S_IDLE;
            default:  r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= S_IDLE;
            r_q.kind  <= K_FETCH;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
            r_q.rdata <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_o    = r_q.st;
    assign kind_o  = r_q.kind;
    assign addr_o  = r_q.addr;
    assign wdata_o = r_q.wdata;
    assign rdata_o = r_q.rdata;
    assign done_o  = r_q.done;

    // R7: a low ready in T2 or a wait state leads to another wait state
    a_r7_wait_inserted: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == S_T2) || (r_q.st == S_TW)) && !ready |=> (r_q.st == S_TW));

    // R8: a pending request never beats hold
    a_r8_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == S_IDLE) && hold && req_valid) |=> (r_q.st == S_HOLD));

endmodule

// File: rtl/bcc_drive.sv
module bcc_drive
    import bcc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  state_e        st,
    input  kind_e         kind,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [AW-DW-1:0] a_hi,
    output logic          addr_oe,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          inta_n,
    output logic          strobe_oe,
    output logic          io_m,
    output logic          s1,
    output logic          s0,
    output logic          hlda
);

    logic       in_t1, in_data, released;
    logic [2:0] code;

    always_comb begin
        in_t1    = (st == S_T1);
        in_data  = (st == S_T2) || (st == S_TW) || (st == S_T3);
        released = (st == S_HOLD) || (st == S_REGAIN);
        code     = status_code(kind);

        ale       = in_t1;
        hlda      = (st == S_HOLD);
        addr_oe   = !released && (st != S_HALT);
        strobe_oe = !released;
        a_hi      = addr[AW-1:DW];
        ad_out    = in_t1 ? addr[DW-1:0] : wdata;
        ad_oe     = in_t1 || (in_data && is_wr(kind));
        rd_n      = !(in_data && is_rd(kind));
        wr_n      = !(in_data && is_wr(kind));
        inta_n    = !(in_data && (kind == K_INTA));
        io_m      = code[2];
        s1        = code[1];
        s0        = code[0];
    end

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_done,
    input  logic             ready,
    input  logic             hold,
    output logic             hlda,
    output logic [DW-1:0]    ad_out,
    input  logic [DW-1:0]    ad_in,
    output logic             ad_oe,
    output logic [AW-DW-1:0] a_hi,
    output logic             addr_oe,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             inta_n,
    output logic             strobe_oe,
    output logic             io_m,
    output logic             s1,
    output logic             s0
);

    state_e        st;
    kind_e         kind;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;

    bcc_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ready      (ready),
        .hold       (hold),
        .ad_in      (ad_in),
        .st_o       (st),
        .kind_o     (kind),
        .addr_o     (addr),
        .wdata_o    (wdata),
        .rdata_o    (rsp_rdata),
        .done_o     (rsp_done),
        .req_ready_o(req_ready)
    );

    bcc_drive #(.AW(AW), .DW(DW)) u_drive (
        .st       (st),
        .kind     (kind),
        .addr     (addr),
        .wdata    (wdata),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .a_hi     (a_hi),
        .addr_oe  (addr_oe),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .inta_n   (inta_n),
        .strobe_oe(strobe_oe),
        .io_m     (io_m),
        .s1       (s1),
        .s0       (s0),
        .hlda     (hlda)
    );

    // R2: the latch strobe lasts one clock and moves on to the data states
    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale && strobe_oe);

    // R7: the strobe in use stays put across a wait state
    a_r7_strobe_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_T2) || (st == S_TW)) && !ready |=> $stable({rd_n, wr_n, inta_n}));

    // R8: granted bus means every driver is released
    a_r8_float_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> !ad_oe && !addr_oe && !strobe_oe);

    // R9: one released clock after the grant drops, then drivers return
    a_r9_regain_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hlda) |-> !addr_oe ##1 (addr_oe && strobe_oe));

    // R10: halt floats address and data
    a_r10_halt_float: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HALT) |-> !addr_oe && !ad_oe && rd_n && wr_n && inta_n
                           && ({io_m, s1, s0} == 3'b000));

endmodule

// File: tb/bus_cycle_ctrl_tb.sv
module bus_cycle_ctrl_tb;

    localparam int P_IDLE = 0, P_T1 = 1, P_T2 = 2, P_TW = 3, P_T3 = 4,
                   P_HALT = 5, P_HOLD = 6, P_REGAIN = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        req_ready;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic        ready = 1'b1;
    logic        hold = 1'b0;
    logic        hlda;
    logic [7:0]  ad_out;
    logic [7:0]  ad_in = 8'h0;
    logic        ad_oe;
    logic [7:0]  a_hi;
    logic        addr_oe, ale, rd_n, wr_n, inta_n, strobe_oe, io_m, s1, s0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int waits_left = 0;

    // reference model state
    int          m_ph = P_IDLE;
    logic [2:0]  m_kind = 3'd0;
    logic [15:0] m_addr = 16'h0;
    logic [7:0]  m_wd = 8'h0;
    logic [7:0]  m_rd = 8'h0;
    logic        m_done = 1'b0;

    always #2 clk = ~clk;

    bus_cycle_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .ready(ready), .hold(hold),
        .hlda(hlda), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .a_hi(a_hi),
        .addr_oe(addr_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
        .strobe_oe(strobe_oe), .io_m(io_m), .s1(s1), .s0(s0)
    );

    function automatic logic [2:0] code_of(logic [2:0] k);
        case (k)
            3'd0: return 3'b011;
            3'd1: return 3'b010;
            3'd2: return 3'b001;
            3'd3: return 3'b110;
            3'd4: return 3'b101;
            3'd5: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [7:0] memf(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = P_IDLE; m_kind = 3'd0; m_addr = 16'h0; m_wd = 8'h0;
            m_rd = 8'h0; m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            if (m_ph == P_IDLE || m_ph == P_HALT) begin
                if (hold) m_ph = P_HOLD;
                else if (req_valid) begin
                    m_kind = req_kind; m_addr = req_addr; m_wd = req_wdata;
                    if (req_kind == 3'd6) begin m_ph = P_HALT; m_done = 1'b1; end
                    else m_ph = P_T1;
                end
            end else if (m_ph == P_T1) m_ph = P_T2;
            else if (m_ph == P_T2 || m_ph == P_TW) m_ph = ready ? P_T3 : P_TW;
            else if (m_ph == P_T3) begin
                m_ph = P_IDLE; m_done = 1'b1;
                if (m_kind == 3'd0 || m_kind == 3'd1 || m_kind == 3'd3 || m_kind == 3'd5)
                    m_rd = ad_in;
            end else if (m_ph == P_HOLD) m_ph = hold ? P_HOLD : P_REGAIN;
            else m_ph = P_IDLE;
        end
    end

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit act, rdk, wrk;
        logic [2:0] c;
        act = (m_ph == P_T2 || m_ph == P_TW || m_ph == P_T3);
        rdk = (m_kind == 3'd0 || m_kind == 3'd1 || m_kind == 3'd3);
        wrk = (m_kind == 3'd2 || m_kind == 3'd4);
        c   = code_of(m_kind);
        chk("R2 ale", {15'd0, ale}, {15'd0, m_ph == P_T1});
        chk("R4 rd_n", {15'd0, rd_n}, {15'd0, !(act && rdk)});
        chk("R5 wr_n", {15'd0, wr_n}, {15'd0, !(act && wrk)});
        chk("R6 inta_n", {15'd0, inta_n}, {15'd0, !(act && m_kind == 3'd5)});
        chk("R8 hlda", {15'd0, hlda}, {15'd0, m_ph == P_HOLD});
        chk("R8 addr_oe", {15'd0, addr_oe},
            {15'd0, !(m_ph == P_HOLD || m_ph == P_REGAIN || m_ph == P_HALT)});
        chk("R8 strobe_oe", {15'd0, strobe_oe},
            {15'd0, !(m_ph == P_HOLD || m_ph == P_REGAIN)});
        chk("R5 ad_oe", {15'd0, ad_oe}, {15'd0, (m_ph == P_T1) || (act && wrk)});
        chk("R11 rsp_done", {15'd0, rsp_done}, {15'd0, m_done});
        chk("R11 req_ready", {15'd0, req_ready},
            {15'd0, (m_ph == P_IDLE || m_ph == P_HALT) && !hold});
        chk("R3 s1s0", {14'd0, s1, s0}, {14'd0, c[1:0]});
        if (addr_oe) begin
            chk("R3 io_m", {15'd0, io_m}, {15'd0, c[2]});
            chk("R2 a_hi", {8'd0, a_hi}, {8'd0, m_addr[15:8]});
        end
        if (m_ph == P_T1) chk("R2 ad_out addr", {8'd0, ad_out}, {8'd0, m_addr[7:0]});
        if (act && wrk) chk("R5 ad_out data", {8'd0, ad_out}, {8'd0, m_wd});
        if (m_done) chk("R4 rsp_rdata", {8'd0, rsp_rdata}, {8'd0, m_rd});
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
        if ((m_ph == P_T2 || m_ph == P_TW) && waits_left > 0) begin
            ready = 1'b0;
            waits_left--;
        end else begin
            ready = 1'b1;
        end
        ad_in = memf(m_addr);
    endtask

    task automatic do_cycle(logic [2:0] k, logic [15:0] a, logic [7:0] w,
                            int nw, bit hold_mid);
        int act_n = 0;
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = w;
        waits_left = nw;
        tick();
        req_valid = 1'b0;
        if (hold_mid) hold = 1'b1;
        for (int i = 0; i < 60; i++) begin
            tick();
            if (!rd_n || !wr_n || !inta_n) act_n++;
            if (rsp_done) break;
        end
        chk("R7 strobe length", act_n[15:0], 16'(2 + nw));
        if (hold_mid) chk("R8 no grant mid-cycle", {15'd0, hlda}, 16'd0);
    endtask

    task automatic release_hold();
        for (int i = 0; i < 3; i++) tick();
        chk("R8 granted", {15'd0, hlda}, 16'd1);
        chk("R8 ad floated", {15'd0, ad_oe}, 16'd0);
        hold = 1'b0;
        tick();
        chk("R9 hlda dropped", {15'd0, hlda}, 16'd0);
        chk("R9 still released", {15'd0, addr_oe}, 16'd0);
        tick();
        chk("R9 drivers back", {14'd0, addr_oe, strobe_oe}, 16'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 strobes high", {13'd0, rd_n, wr_n, inta_n}, 16'd7);
        chk("R1 quiet", {12'd0, ale, hlda, ad_oe, rsp_done}, 16'd0);
        chk("R1 req_ready", {15'd0, req_ready}, 16'd1);
        tick();

        do_cycle(3'd0, 16'h1234, 8'h00, 0, 0); // fetch
        chk("R4 fetch data", {8'd0, rsp_rdata}, {8'd0, memf(16'h1234)});
        do_cycle(3'd1, 16'hA5C3, 8'h00, 2, 0); // memory read, waits
        chk("R4 read data", {8'd0, rsp_rdata}, {8'd0, memf(16'hA5C3)});
        do_cycle(3'd2, 16'h0F0F, 8'h9C, 1, 0); // memory write
        do_cycle(3'd3, 16'h0077, 8'h00, 0, 0); // IO read
        do_cycle(3'd4, 16'h0042, 8'h3E, 3, 0); // IO write
        do_cycle(3'd5, 16'hFFEE, 8'h00, 1, 0); // interrupt acknowledge
        chk("R6 opcode", {8'd0, rsp_rdata}, {8'd0, memf(16'hFFEE)});

        // R8 hold while idle beats a pending request
        hold = 1'b1;
        req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h2222;
        tick();
        chk("R8 request refused", {15'd0, ale}, 16'd0);
        req_valid = 1'b0;
        release_hold();

        // R8 hold raised inside a stretched cycle
        do_cycle(3'd1, 16'h3456, 8'h00, 2, 1);
        release_hold();

        // R10 halt and leave it
        req_valid = 1'b1; req_kind = 3'd6; req_addr = 16'h5555;
        tick();
        req_valid = 1'b0;
        chk("R10 halt done", {15'd0, rsp_done}, 16'd1);
        chk("R10 halt floats", {14'd0, addr_oe, ad_oe}, 16'd0);
        chk("R10 halt code", {14'd0, s1, s0}, 16'd0);
        tick(); tick();
        chk("R11 done single", {15'd0, rsp_done}, 16'd0);
        do_cycle(3'd0, 16'h8001, 8'h00, 0, 0);
        chk("R10 resumed fetch", {8'd0, rsp_rdata}, {8'd0, memf(16'h8001)});

        // hold during halt
        req_valid = 1'b1; req_kind = 3'd6; tick(); req_valid = 1'b0;
        hold = 1'b1;
        release_hold();
        do_cycle(3'd2, 16'h7E7E, 8'hA1, 0, 0);

        tick();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule